// File: doc/BRIEF.md
# Banked cartridge dump sequencer

This sequencer sits above a byte-wide cartridge bus controller and turns a single start pulse into a complete, ordered dump. It makes one bus request at a time. Each request is a ROM read, an SRAM read, or a write to the cartridge's bank register. It then streams every byte it reads on a valid/ready output.

In ROM mode it first probes four signature bytes near the top of the first 16 KB to decide whether the cartridge holds two banks. A two-bank cartridge carries its own bank-switch values in two of those bytes. When it is found, the sequencer selects bank 0 and reads the lower half of the ROM. It then selects bank 1 and reads the upper half. Last, it writes the bank-0 value again. A plain cartridge is read straight through with no bank writes. In SRAM mode the sequencer reads the save memory linearly and skips the probe.

The ROM span (`ROM_AW` address bits, default 22, which is 4 MB) and the SRAM span (`SRAM_AW`, default 15, which is 32 KB) are parameters. The probe addresses and the bank register address are fixed bus addresses. After each ROM dump the probe verdict and the two captured bank values stay visible on the outputs.

Top module: `cart_dump_seq`

## Requirements
- R1: A ROM dump first issues probe reads (kind 0) in this order: 0x3FFC, then 0x3FFD only if 0x3FFC read non-zero, then 0x3FFB only if 0x3FFD read non-zero, then 0x3FFF only if 0x3FFB read zero; no other probe read is made.
- R2: At the start of every ROM dump, multipack, bank0_val and bank1_val are cleared. A non-zero 0x3FFC value is captured in bank0_val, and a non-zero 0x3FFD value is captured in bank1_val. multipack is set only when 0x3FFF is also read and is zero. When 0x3FFF is read non-zero, both bank values are cleared.
- R3: Without multipack, the ROM dump reads (kind 0) every address from 0 to 2^ROM_AW-1 in ascending order, with no bank write.
- R4: With multipack, the dump does the following in order. It writes bank0_val (kind 2, address 0x00FFFF, upper bits zero) and reads the lower half in ascending order. It writes bank1_val to the same address and reads the upper half in ascending order. It then writes bank0_val once more.
- R5: An SRAM dump (sram_mode high at start) issues no probe and no bank write. It reads (kind 1) every address from 0 to 2^SRAM_AW-1 in ascending order and leaves multipack and the bank values unchanged.
- R6: At most one bus request is outstanding. A request that is not yet accepted keeps req_valid, kind, address and write data stable.
- R7: Every read response produces exactly one output byte, in request order. Under backpressure out_valid and out_data hold until out_ready, and no read is skipped or reissued.
- R8: done pulses high for exactly one cycle per dump. For a multipack ROM dump it pulses after the final bank write completes; otherwise it pulses after the last byte is accepted. A start while a dump runs is ignored.
- R9: After reset, req_valid, out_valid, done and multipack are low and both bank values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a dump (taken only when idle) |
| sram_mode | input | 1 | At start: 1 = SRAM dump, 0 = ROM dump |
| req_valid | output | 1 | Bus request present |
| req_ready | input | 1 | Bus controller accepts the request |
| req_kind | output | 2 | 0 ROM read, 1 SRAM read, 2 bank register write |
| req_addr | output | 22 | Bus address |
| req_wdata | output | 8 | Write data for a bank write |
| rsp_valid | input | 1 | One-cycle completion of the outstanding request |
| rsp_data | input | 8 | Read data with rsp_valid |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Dumped byte |
| done | output | 1 | One-cycle end-of-dump pulse |
| multipack | output | 1 | Last probe found a two-bank cartridge |
| bank0_val | output | 8 | Captured bank-0 switch value |
| bank1_val | output | 8 | Captured bank-1 switch value |

## Verification
The assertions assume the bus controller raises rsp_valid for exactly one cycle per accepted request, never before acceptance and never without a request outstanding. The bench bus model keeps to this: it lowers req_ready while a request is pending and answers after a random latency of one to three cycles. Acceptance on req_ready and consumption on out_ready are both randomised, so the stability properties are exercised under long stalls. The model changes its inputs only on the falling clock edge.

// File: rtl/cart_dump_pkg.sv
package cart_dump_pkg;

    typedef enum logic [1:0] {
        KIND_ROM_RD  = 2'd0,
        KIND_SRAM_RD = 2'd1,
        KIND_BANK_WR = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRB_REQ,
        ST_PRB_RSP,
        ST_BNK_REQ,
        ST_BNK_RSP,
        ST_RD_REQ,
        ST_RD_RSP,
        ST_OUT
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_LOW     = 2'd0,
        PH_HIGH    = 2'd1,
        PH_RESTORE = 2'd2
    } bank_ph_e;

    typedef struct packed {
        seq_st_e    st;
        logic [1:0] pidx;
        logic       sram;
        logic       mp;
        logic [7:0] b0;
        logic [7:0] b1;
        bank_ph_e   bph;
        logic       done;
    } seq_regs_t;

    localparam logic [15:0] BANK_REG_ADDR = 16'hFFFF;

    // probe order: bank-0 value, bank-1 value, zero guard, zero guard
    function automatic logic [15:0] sig_addr(input logic [1:0] idx);
        case (idx)
            2'd0:    sig_addr = 16'h3FFC;
            2'd1:    sig_addr = 16'h3FFD;
            2'd2:    sig_addr = 16'h3FFB;
            default: sig_addr = 16'h3FFF;
        endcase
    endfunction

endpackage

// File: rtl/cart_dump_ctr.sv
module cart_dump_ctr #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cart_dump_hold.sv
module cart_dump_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic          vld_d, vld_q;
    logic [DW-1:0] dat_d, dat_q;

    always_comb begin
        vld_d = vld_q;
        dat_d = dat_q;
        if (load) begin
            vld_d = 1'b1;
            dat_d = din;
        end else if (vld_q && out_ready) begin
            vld_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
endmodule

// File: rtl/cart_dump_seq.sv
module cart_dump_seq
    import cart_dump_pkg::*;
#(
    parameter int BUS_AW  = 22,
    parameter int ROM_AW  = 22,
    parameter int SRAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sram_mode,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_kind,
    output logic [BUS_AW-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              done,
    output logic              multipack,
    output logic [7:0]        bank0_val,
    output logic [7:0]        bank1_val
);
    localparam int CW = (ROM_AW > SRAM_AW) ? ROM_AW : SRAM_AW;
    localparam logic [CW-1:0] ROM_LAST      = CW'((64'd1 << ROM_AW) - 64'd1);
    localparam logic [CW-1:0] ROM_HALF_LAST = CW'((64'd1 << (ROM_AW - 1)) - 64'd1);
    localparam logic [CW-1:0] SRAM_LAST     = CW'((64'd1 << SRAM_AW) - 64'd1);

    seq_regs_t r_q, r_d;

    logic          ctr_clr, ctr_inc, hold_load, probe_end;
    logic [CW-1:0] cnt;
    logic          at_last, at_half;
    req_kind_e     kind;

    cart_dump_ctr #(.W(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc), .cnt(cnt)
    );

    cart_dump_hold #(.DW(8)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .din(rsp_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );

    assign at_last = r_q.sram ? (cnt == SRAM_LAST) : (cnt == ROM_LAST);
    assign at_half = (cnt == ROM_HALF_LAST);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        hold_load = 1'b0;
        probe_end = 1'b0;
        req_valid = 1'b0;
        kind      = KIND_ROM_RD;
        req_addr  = '0;
        req_wdata = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctr_clr  = 1'b1;
                    r_d.sram = sram_mode;
                    if (sram_mode) begin
                        r_d.st = ST_RD_REQ;
                    end else begin
                        r_d.mp   = 1'b0;
                        r_d.b0   = '0;
                        r_d.b1   = '0;
                        r_d.pidx = 2'd0;
                        r_d.st   = ST_PRB_REQ;
                    end
                end
            end
            ST_PRB_REQ: begin
                req_valid = 1'b1;
                req_addr  = BUS_AW'(sig_addr(r_q.pidx));
                if (req_ready) r_d.st = ST_PRB_RSP;
            end
            ST_PRB_RSP: begin
                if (rsp_valid) begin
                    case (r_q.pidx)
                        2'd0: begin
                            if (rsp_data != 8'd0) begin
                                r_d.b0   = rsp_data;
                                r_d.pidx = 2'd1;
                                r_d.st   = ST_PRB_REQ;
                            end else probe_end = 1'b1;
                        end
                        2'd1: begin
                            if (rsp_data != 8'd0) begin
                                r_d.b1   = rsp_data;
                                r_d.pidx = 2'd2;
                                r_d.st   = ST_PRB_REQ;
                            end else probe_end = 1'b1;
                        end
                        2'd2: begin
                            if (rsp_data == 8'd0) begin
                                r_d.pidx = 2'd3;
                                r_d.st   = ST_PRB_REQ;
                            end else probe_end = 1'b1;
                        end
                        default: begin
                            probe_end = 1'b1;
                            if (rsp_data == 8'd0) begin
                                r_d.mp = 1'b1;
                            end else begin
                                r_d.b0 = '0;
                                r_d.b1 = '0;
                            end
                        end
                    endcase
                    if (probe_end) begin
                        r_d.bph = PH_LOW;
                        r_d.st  = r_d.mp ? ST_BNK_REQ : ST_RD_REQ;
                    end
                end
            end
            ST_BNK_REQ: begin
                req_valid = 1'b1;
                kind      = KIND_BANK_WR;
                req_addr  = BUS_AW'(BANK_REG_ADDR);
                req_wdata = (r_q.bph == PH_HIGH) ? r_q.b1 : r_q.b0;
                if (req_ready) r_d.st = ST_BNK_RSP;
            end
            ST_BNK_RSP: begin
                if (rsp_valid) begin
                    if (r_q.bph == PH_RESTORE) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ: begin
                req_valid = 1'b1;
                kind      = r_q.sram ? KIND_SRAM_RD : KIND_ROM_RD;
                req_addr  = BUS_AW'(cnt);
                if (req_ready) r_d.st = ST_RD_RSP;
            end
            ST_RD_RSP: begin
                if (rsp_valid) begin
                    hold_load = 1'b1;
                    r_d.st    = ST_OUT;
                end
            end
            ST_OUT: begin
                if (!out_valid) begin
                    if (at_last) begin
                        if (r_q.mp && !r_q.sram) begin
                            r_d.bph = PH_RESTORE;
                            r_d.st  = ST_BNK_REQ;
                        end else begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end
                    end else begin
                        ctr_inc = 1'b1;
                        if (r_q.mp && !r_q.sram && at_half) begin
                            r_d.bph = PH_HIGH;
                            r_d.st  = ST_BNK_REQ;
                        end else begin
                            r_d.st = ST_RD_REQ;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pidx: 2'd0, sram: 1'b0, mp: 1'b0,
                     b0: 8'd0, b1: 8'd0, bph: PH_LOW, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_kind  = kind;
    assign done      = r_q.done;
    assign multipack = r_q.mp;
    assign bank0_val = r_q.b0;
    assign bank1_val = r_q.b1;
endmodule

// File: rtl/cart_dump_chk.sv
module cart_dump_chk #(
    parameter int BUS_AW = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [BUS_AW-1:0] req_addr,
    input logic [7:0]        req_wdata,
    input logic              rsp_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              done
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (req_valid && req_ready) pend_q <= 1'b1;
        else if (rsp_valid)              pend_q <= 1'b0;
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_kind)
                                    && $stable(req_addr) && $stable(req_wdata));

    // R6
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !req_valid);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !pend_q && !req_valid);
endmodule

bind cart_dump_seq cart_dump_chk #(.BUS_AW(BUS_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
);

// File: tb/tb_cart_dump_seq.sv
`timescale 1ns/1ps
module tb_cart_dump_seq;
    localparam int BUS_AW  = 22;
    localparam int ROM_AW  = 6;
    localparam int SRAM_AW = 5;
    localparam int NROM    = 1 << ROM_AW;
    localparam int NSRAM   = 1 << SRAM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, sram_mode = 1'b0;
    logic req_valid, req_ready = 1'b0;
    logic [1:0] req_kind;
    logic [BUS_AW-1:0] req_addr;
    logic [7:0] req_wdata;
    logic rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'd0;
    logic out_valid, out_ready = 1'b0;
    logic [7:0] out_data;
    logic done, multipack;
    logic [7:0] bank0_val, bank1_val;

    always #2.5 clk = ~clk;

    cart_dump_seq #(.BUS_AW(BUS_AW), .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sram_mode(sram_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .multipack(multipack),
        .bank0_val(bank0_val), .bank1_val(bank1_val)
    );

    int checks = 0, failures = 0;
    int rdy_pct = 70, out_pct = 60;
    int done_cnt = 0;
    logic [7:0] sg_c, sg_d, sg_b, sg_f;
    logic [7:0] bank_reg, tb_bank;
    logic exp_mp;
    logic [7:0] exp_b0, exp_b1;
    int busy, lat;
    logic [1:0]  eq_kind[$];
    logic [21:0] eq_addr[$];
    logic [7:0]  eq_wd[$];
    logic [7:0]  eq_data[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] romf(input int a, input logic [7:0] bk);
        romf = 8'(a * 37) ^ bk ^ 8'h5A;
    endfunction
    function automatic logic [7:0] sramf(input int a);
        sramf = 8'(a * 13 + 7);
    endfunction

    task automatic push(input logic [1:0] k, input logic [21:0] a, input logic [7:0] w);
        eq_kind.push_back(k); eq_addr.push_back(a); eq_wd.push_back(w);
    endtask

    task automatic plan_rom(input logic [7:0] sc, sd, sb, sf);
        logic [7:0] b0, b1; logic mp;
        b0 = 0; b1 = 0; mp = 0;
        push(2'd0, 22'h3FFC, 8'd0);
        if (sc != 0) begin
            b0 = sc; push(2'd0, 22'h3FFD, 8'd0);
            if (sd != 0) begin
                b1 = sd; push(2'd0, 22'h3FFB, 8'd0);
                if (sb == 0) begin
                    push(2'd0, 22'h3FFF, 8'd0);
                    if (sf == 0) mp = 1;
                    else begin b0 = 0; b1 = 0; end
                end
            end
        end
        exp_mp = mp; exp_b0 = b0; exp_b1 = b1;
        if (mp) begin
            push(2'd2, 22'h00FFFF, b0);
            for (int a = 0; a < NROM/2; a++) begin push(2'd0, 22'(a), 8'd0); eq_data.push_back(romf(a, b0)); end
            push(2'd2, 22'h00FFFF, b1);
            for (int a = NROM/2; a < NROM; a++) begin push(2'd0, 22'(a), 8'd0); eq_data.push_back(romf(a, b1)); end
            push(2'd2, 22'h00FFFF, b0);
            tb_bank = b0;
        end else begin
            for (int a = 0; a < NROM; a++) begin push(2'd0, 22'(a), 8'd0); eq_data.push_back(romf(a, tb_bank)); end
        end
    endtask

    function automatic string req_tag(input logic [1:0] k, input logic [21:0] a);
        if (k == 2'd2) return "R4";
        if (k == 2'd1) return "R5";
        if (a >= 22'h3000) return "R1";
        return exp_mp ? "R4" : "R3";
    endfunction

    // bus controller and consumer model, acting on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 0; lat = 0; rsp_valid = 0; req_ready = 0; out_ready = 0; bank_reg = 8'd0;
        end else begin
            if (rsp_valid) begin rsp_valid = 0; busy = 0; end
            else if (busy != 0) begin lat--; if (lat == 0) rsp_valid = 1; end
            req_ready = 0;
            if (busy == 0) begin
                req_ready = (($urandom % 100) < rdy_pct);
                if (req_valid && req_ready) begin
                    busy = 1; lat = 1 + ($urandom % 3);
                    if (eq_kind.size() == 0) begin
                        chk(0, req_tag(req_kind, req_addr), "unexpected request addr", int'(req_addr), 0);
                    end else begin
                        logic [1:0] ek; logic [21:0] ea; logic [7:0] ew; string tg;
                        ek = eq_kind.pop_front(); ea = eq_addr.pop_front(); ew = eq_wd.pop_front();
                        tg = req_tag(ek, ea);
                        chk(req_kind == ek, tg, "request kind", int'(req_kind), int'(ek));
                        chk(req_addr == ea, tg, "request addr", int'(req_addr), int'(ea));
                        if (ek == 2'd2) chk(req_wdata == ew, tg, "bank write data", int'(req_wdata), int'(ew));
                    end
                    case (req_kind)
                        2'd2: begin bank_reg = req_wdata; rsp_data = 8'd0; end
                        2'd1: rsp_data = sramf(int'(req_addr));
                        default: begin
                            case (req_addr)
                                22'h3FFC: rsp_data = sg_c;
                                22'h3FFD: rsp_data = sg_d;
                                22'h3FFB: rsp_data = sg_b;
                                22'h3FFF: rsp_data = sg_f;
                                default:  rsp_data = romf(int'(req_addr), bank_reg);
                            endcase
                        end
                    endcase
                end
            end
            out_ready = (($urandom % 100) < out_pct);
            if (out_valid && out_ready) begin
                if (eq_data.size() == 0) chk(0, "R7", "unexpected output byte", int'(out_data), 0);
                else begin
                    logic [7:0] ed;
                    ed = eq_data.pop_front();
                    chk(out_data == ed, "R7", "stream byte", int'(out_data), int'(ed));
                end
            end
            if (done) done_cnt++;
        end
    end

    task automatic pulse_start(input logic sm);
        @(negedge clk); start = 1'b1; sram_mode = sm;
        @(negedge clk); start = 1'b0; sram_mode = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1'b1, tag, "done seen", int'(done), 1);
        chk(eq_kind.size() == 0, tag, "requests left unissued", eq_kind.size(), 0);
        chk(eq_data.size() == 0, tag, "bytes left unstreamed", eq_data.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", int'(done), 0);
        chk(done_cnt == 1, "R8", "done pulses per dump", done_cnt, 1);
    endtask

    task automatic run_rom(input logic [7:0] sc, sd, sb, sf, input bit restart);
        string tg;
        sg_c = sc; sg_d = sd; sg_b = sb; sg_f = sf;
        plan_rom(sc, sd, sb, sf);
        tg = exp_mp ? "R4" : "R3";
        done_cnt = 0;
        pulse_start(1'b0);
        if (restart) begin
            repeat (25) @(negedge clk);
            pulse_start(1'b1);   // R8: ignored while running
        end
        wait_done(tg);
        chk(multipack == exp_mp, "R2", "multipack", int'(multipack), int'(exp_mp));
        chk(bank0_val == exp_b0, "R2", "bank0 value", int'(bank0_val), int'(exp_b0));
        chk(bank1_val == exp_b1, "R2", "bank1 value", int'(bank1_val), int'(exp_b1));
    endtask

    task automatic run_sram();
        logic pm; logic [7:0] p0, p1;
        pm = multipack; p0 = bank0_val; p1 = bank1_val;
        for (int a = 0; a < NSRAM; a++) begin push(2'd1, 22'(a), 8'd0); eq_data.push_back(sramf(a)); end
        done_cnt = 0;
        pulse_start(1'b1);
        wait_done("R5");
        chk(multipack == pm, "R5", "multipack untouched", int'(multipack), int'(pm));
        chk(bank0_val == p0, "R5", "bank0 untouched", int'(bank0_val), int'(p0));
        chk(bank1_val == p1, "R5", "bank1 untouched", int'(bank1_val), int'(p1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tb_bank = 8'd0;
        sg_c = 0; sg_d = 0; sg_b = 0; sg_f = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9
        chk(req_valid == 1'b0, "R9", "req_valid after reset", int'(req_valid), 0);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
        chk(multipack == 1'b0, "R9", "multipack after reset", int'(multipack), 0);
        chk(bank0_val == 8'd0 && bank1_val == 8'd0, "R9", "bank values after reset",
            int'({bank0_val, bank1_val}), 0);

        run_rom(8'h00, 8'h11, 8'h00, 8'h00, 1'b0);   // R3 plain cartridge
        run_rom(8'h28, 8'h2E, 8'h00, 8'h00, 1'b1);   // R4 2 MB pair, restart ignored
        run_rom(8'h20, 8'h31, 8'h00, 8'h00, 1'b0);   // R4 4 MB pair
        run_sram();                                  // R5 after multipack
        run_rom(8'h44, 8'h00, 8'h00, 8'h00, 1'b0);   // R1 stop after second probe
        run_rom(8'h44, 8'h55, 8'h01, 8'h00, 1'b0);   // R1 non-zero guard byte
        run_rom(8'h44, 8'h55, 8'h00, 8'h80, 1'b0);   // R2 values cleared
        out_pct = 10;                                // R7 heavy backpressure
        run_rom(8'h28, 8'h2E, 8'h00, 8'h00, 1'b0);
        out_pct = 60;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a, b, c, d;
            a = (($urandom % 4) == 0) ? 8'd0 : 8'($urandom);
            b = (($urandom % 4) == 0) ? 8'd0 : 8'($urandom);
            c = (($urandom % 3) == 0) ? 8'($urandom | 1) : 8'd0;
            d = (($urandom % 3) == 0) ? 8'($urandom | 1) : 8'd0;
            rdy_pct = 30 + int'($urandom % 70);
            run_rom(a, b, c, d, 1'b0);
        end
        run_sram();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule